// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets a debugger reach system memory without involving a processor hart. A debug transport performs single-cycle register reads and writes on three registers: a control/status word, an address register and a data register. Some of these accesses have side effects that start one bus transaction on a simple valid/ready memory port. Writing the data register starts a store of that value. Writing the address register can start a load, and so can reading the data register. Each mode is selected by its own control bit.

A 3-bit size code sets the width of each access to 1, 2, 4 or 8 bytes. When auto-increment is enabled, the address advances by that width after each access that completes without error. This lets a debugger stream through memory with one register access per word. Three conditions are reported in the status word: a busy flag, a sticky flag for register accesses that arrived while busy, and an error field. A nonzero error field blocks every new transaction until software clears it.

Top module: `sbus_access_engine`

## Requirements
- R1: A write to the data register (reg_sel 2) while idle with a zero error field stores the value in the data register. The next cycle it raises bus_req_valid with bus_req_write 1, the address register on bus_req_addr, the data register on bus_req_wdata and the size code on bus_req_size.
- R2: The size code sits at control bits 19:17. Codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. When control bit 16 is 1, a successful access adds that byte count to the address, modulo 2^32. Otherwise the address is left unchanged.
- R3: Size codes 4 to 7 are rejected, and code 3 is also rejected when the 8-byte option is disabled. A rejected access issues no transaction, leaves the address unchanged and sets the error field (bits 14:12) to 4. A rejected data write still loads the data register.
- R4: When control bit 20 is 1, a write to the address register (reg_sel 1) loads the address and starts a bus read. A successful read response is stored in the data register.
- R5: When control bit 15 is 1, a read of the data register returns its current value and then starts a bus read at the current address. When the bit is 0, reading the data register has no side effect.
- R6: Control bit 21 (busy) reads 1 from the cycle after a transaction starts until the cycle after its response. bus_req_valid is never high while busy is 0.
- R7: A register access of any kind that arrives while busy sets control bit 22. That access has no other effect: no register changes and no transaction starts. Writing a 1 to bit 22 through a control write (reg_sel 0) while idle clears it.
- R8: A response with bus_rsp_error 1 sets the error field to 2. It leaves the address and data registers unchanged.
- R9: While the error field is nonzero, no access starts a transaction. A control write clears each error-field bit written with a 1 and loads bits 20, 19:17, 16 and 15.
- R10: While bus_req_valid is high and bus_req_ready is low, the request keeps valid, address, write flag, size and write data unchanged.
- R11: After reset, the control, address and data registers read 0 and bus_req_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 control/status, 1 address, 2 data |
| reg_wdata | input | XLEN | Register write value |
| reg_rdata | output | XLEN | Selected register value (combinational) |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_write | output | 1 | 1 = store, 0 = load |
| bus_req_addr | output | XLEN | Byte address |
| bus_req_size | output | 3 | Size code of the access |
| bus_req_wdata | output | XLEN | Store data |
| bus_rsp_valid | input | 1 | Response strobe |
| bus_rsp_error | input | 1 | Response carries an error |
| bus_rsp_rdata | input | XLEN | Load data |

## Verification
The engine is driven with stores, loads started by an address write and loads started by a data read, over all four legal size codes. This separates the per-size increment amounts and the wrap at the top of the address space. Illegal size codes and bus error responses are applied in turn and are then followed by accesses that must stay blocked. This tells apart a size rejection, which gives code 4 and leaves the data register loaded, from a bus fault, which gives code 2 and leaves the data register unchanged. A slave that stalls its ready and answers late exercises request hold and the busy window. Register accesses issued inside that window show that they are dropped and flagged.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} bus_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int BIT_BERR = 22;
  localparam int BIT_BUSY = 21;
  localparam int BIT_RDA  = 20;
  localparam int SIZE_LO  = 17;
  localparam int BIT_INC  = 16;
  localparam int BIT_RDD  = 15;
  localparam int ERR_LO   = 12;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_BUS  = 3'd2;
  localparam logic [2:0] ERR_SIZE = 3'd4;

  function automatic logic [3:0] size_bytes(input logic [2:0] code);
    case (code)
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd4;
      3'd3: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/sba_size_decode.sv
module sba_size_decode #(
  parameter int XLEN        = 32,
  parameter bit ALLOW_DWORD = 1'b1
) (
  input  logic [2:0]      size_code,
  output logic            legal,
  output logic [XLEN-1:0] incr
);
  import sba_pkg::*;

  generate
    if (ALLOW_DWORD) begin : g_dword
      assign legal = (size_code <= 3'd3);
    end else begin : g_word
      assign legal = (size_code <= 3'd2);
    end
  endgenerate

  assign incr = {{(XLEN-4){1'b0}}, size_bytes(size_code)};
endmodule

// File: rtl/sba_bus_fsm.sv
module sba_bus_fsm #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_write,
  input  logic            bus_req_ready,
  input  logic            bus_rsp_valid,
  input  logic            bus_rsp_error,
  input  logic [XLEN-1:0] bus_rsp_rdata,
  output logic            bus_req_valid,
  output logic            bus_req_write,
  output logic            busy,
  output logic            done_ok,
  output logic            done_err,
  output logic            done_read,
  output logic [XLEN-1:0] rd_data
);
  import sba_pkg::*;

  bus_state_e state_q;
  logic       write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_REQ;
          write_q <= start_write;
        end
        ST_REQ:  if (bus_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (bus_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic rsp_take;
  assign rsp_take      = (state_q == ST_WAIT) && bus_rsp_valid;
  assign bus_req_valid = (state_q == ST_REQ);
  assign bus_req_write = write_q;
  assign busy          = (state_q != ST_IDLE);
  assign done_ok       = rsp_take && !bus_rsp_error;
  assign done_err      = rsp_take && bus_rsp_error;
  assign done_read     = !write_q;
  assign rd_data       = bus_rsp_rdata;
endmodule

// File: rtl/sbus_access_engine.sv
module sbus_access_engine #(
  parameter int XLEN        = 32,
  parameter bit ALLOW_DWORD = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_valid,
  input  logic            reg_write,
  input  logic [1:0]      reg_sel,
  input  logic [XLEN-1:0] reg_wdata,
  output logic [XLEN-1:0] reg_rdata,
  output logic            bus_req_valid,
  input  logic            bus_req_ready,
  output logic            bus_req_write,
  output logic [XLEN-1:0] bus_req_addr,
  output logic [2:0]      bus_req_size,
  output logic [XLEN-1:0] bus_req_wdata,
  input  logic            bus_rsp_valid,
  input  logic            bus_rsp_error,
  input  logic [XLEN-1:0] bus_rsp_rdata
);
  import sba_pkg::*;

  logic [XLEN-1:0] addr_q, data_q;
  logic [2:0]      err_q, size_q;
  logic            berr_q, rda_q, inc_q, rdd_q;

  logic            busy, done_ok, done_err, done_read;
  logic [XLEN-1:0] rd_data, incr;
  logic            size_legal;

  // access decode: named events shared with the checker
  logic acc_ok, wr_ctrl, addr_load, data_load, data_read;
  logic want_read, want_write, want, size_reject, start, inc_event, busy_hit;

  assign acc_ok      = reg_valid && !busy;
  assign busy_hit    = reg_valid && busy;
  assign wr_ctrl     = acc_ok && reg_write  && (reg_sel == SEL_CTRL);
  assign addr_load   = acc_ok && reg_write  && (reg_sel == SEL_ADDR);
  assign data_load   = acc_ok && reg_write  && (reg_sel == SEL_DATA);
  assign data_read   = acc_ok && !reg_write && (reg_sel == SEL_DATA);
  assign want_read   = (addr_load && rda_q) || (data_read && rdd_q);
  assign want_write  = data_load;
  assign want        = (want_read || want_write) && (err_q == ERR_NONE);
  assign size_reject = want && !size_legal;
  assign start       = want && size_legal;
  assign inc_event   = done_ok && inc_q;

  sba_size_decode #(.XLEN(XLEN), .ALLOW_DWORD(ALLOW_DWORD)) u_size (
    .size_code (size_q),
    .legal     (size_legal),
    .incr      (incr)
  );

  sba_bus_fsm #(.XLEN(XLEN)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_write   (want_write),
    .bus_req_ready (bus_req_ready),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_error (bus_rsp_error),
    .bus_rsp_rdata (bus_rsp_rdata),
    .bus_req_valid (bus_req_valid),
    .bus_req_write (bus_req_write),
    .busy          (busy),
    .done_ok       (done_ok),
    .done_err      (done_err),
    .done_read     (done_read),
    .rd_data       (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      err_q  <= ERR_NONE;
      size_q <= 3'd0;
      berr_q <= 1'b0;
      rda_q  <= 1'b0;
      inc_q  <= 1'b0;
      rdd_q  <= 1'b0;
    end else begin
      if (addr_load)      addr_q <= reg_wdata;
      else if (inc_event) addr_q <= addr_q + incr;

      if (data_load)                   data_q <= reg_wdata;
      else if (done_ok && done_read)   data_q <= rd_data;

      if (done_err)         err_q <= ERR_BUS;
      else if (size_reject) err_q <= ERR_SIZE;
      else if (wr_ctrl)     err_q <= err_q & ~reg_wdata[ERR_LO +: 3];

      if (busy_hit)                          berr_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[BIT_BERR]) berr_q <= 1'b0;

      if (wr_ctrl) begin
        rda_q  <= reg_wdata[BIT_RDA];
        size_q <= reg_wdata[SIZE_LO +: 3];
        inc_q  <= reg_wdata[BIT_INC];
        rdd_q  <= reg_wdata[BIT_RDD];
      end
    end
  end

  logic [XLEN-1:0] ctrl_word;
  always_comb begin
    ctrl_word                = '0;
    ctrl_word[BIT_BERR]      = berr_q;
    ctrl_word[BIT_BUSY]      = busy;
    ctrl_word[BIT_RDA]       = rda_q;
    ctrl_word[SIZE_LO +: 3]  = size_q;
    ctrl_word[BIT_INC]       = inc_q;
    ctrl_word[BIT_RDD]       = rdd_q;
    ctrl_word[ERR_LO +: 3]   = err_q;
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_word;
      SEL_ADDR: reg_rdata = addr_q;
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign bus_req_addr  = addr_q;
  assign bus_req_size  = size_q;
  assign bus_req_wdata = data_q;
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_valid,
  input logic            start,
  input logic            size_reject,
  input logic            inc_event,
  input logic            addr_load,
  input logic            busy,
  input logic            done_err,
  input logic            berr_q,
  input logic [2:0]      err_q,
  input logic [XLEN-1:0] addr_q,
  input logic [XLEN-1:0] incr,
  input logic            bus_req_valid,
  input logic            bus_req_ready,
  input logic            bus_req_write,
  input logic [XLEN-1:0] bus_req_addr,
  input logic [2:0]      bus_req_size,
  input logic [XLEN-1:0] bus_req_wdata
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> bus_req_valid);

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_event |=> addr_q == $past(addr_q) + $past(incr));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_event || addr_load) |=> $stable(addr_q));

  assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    size_reject |=> !bus_req_valid && err_q == 3'd4);

  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> busy);

  assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && busy |=> berr_q);

  assert_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> err_q == 3'd2);

  assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 3'd0) && !busy |=> !bus_req_valid);

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_write) && $stable(bus_req_size) && $stable(bus_req_wdata));
endmodule

bind sbus_access_engine sba_checker #(.XLEN(XLEN)) u_sba_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_valid     (reg_valid),
  .start         (start),
  .size_reject   (size_reject),
  .inc_event     (inc_event),
  .addr_load     (addr_load),
  .busy          (busy),
  .done_err      (done_err),
  .berr_q        (berr_q),
  .err_q         (err_q),
  .addr_q        (addr_q),
  .incr          (incr),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_req_write (bus_req_write),
  .bus_req_addr  (bus_req_addr),
  .bus_req_size  (bus_req_size),
  .bus_req_wdata (bus_req_wdata)
);

// File: tb/test_sbus_access_engine.sv
`timescale 1ns/1ps
module test_sbus_access_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        bus_req_valid, bus_req_ready = 1'b0, bus_req_write;
  logic [31:0] bus_req_addr, bus_req_wdata;
  logic [2:0]  bus_req_size;
  logic        bus_rsp_valid = 1'b0, bus_rsp_error = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;

  always #5 clk = ~clk;

  sbus_access_engine i_sbus_access_engine (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_error(bus_rsp_error),
    .bus_rsp_rdata(bus_rsp_rdata));

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_state = 0;   // 0 idle, 1 request, 2 waiting
  logic        m_wr = 0, m_berr = 0, m_rda = 0, m_inc = 0, m_rdd = 0;
  logic [2:0]  m_size = 0, m_err = 0;
  logic [31:0] m_addr = 0, m_data = 0;

  task automatic m_go(input logic is_wr);
    if (m_err == 0) begin
      if (m_size > 3) m_err = 3'd4;
      else begin m_state = 1; m_wr = is_wr; end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_wr = 0; m_berr = 0; m_rda = 0; m_inc = 0; m_rdd = 0;
      m_size = 0; m_err = 0; m_addr = 0; m_data = 0;
    end else begin
      bit was_busy;
      was_busy = (m_state != 0);
      if (m_state == 1) begin
        if (bus_req_ready) m_state = 2;
      end else if (m_state == 2 && bus_rsp_valid) begin
        m_state = 0;
        if (bus_rsp_error) m_err = 3'd2;
        else begin
          if (!m_wr) m_data = bus_rsp_rdata;
          if (m_inc) m_addr = m_addr + (32'd1 << m_size);
        end
      end
      if (reg_valid) begin
        if (was_busy) m_berr = 1;
        else if (reg_write && reg_sel == 0) begin
          m_rda = reg_wdata[20]; m_size = reg_wdata[19:17];
          m_inc = reg_wdata[16]; m_rdd = reg_wdata[15];
          m_err = m_err & ~reg_wdata[14:12];
          if (reg_wdata[22]) m_berr = 0;
        end else if (reg_write && reg_sel == 1) begin
          m_addr = reg_wdata;
          if (m_rda) m_go(1'b0);
        end else if (reg_write && reg_sel == 2) begin
          m_data = reg_wdata;
          m_go(1'b1);
        end else if (!reg_write && reg_sel == 2 && m_rdd) m_go(1'b0);
      end
    end
  end

  function automatic logic [31:0] m_ctrl();
    return ({31'd0, m_berr} << 22) | ({31'd0, m_state != 0} << 21) |
           ({31'd0, m_rda} << 20) | ({29'd0, m_size} << 17) |
           ({31'd0, m_inc} << 16) | ({31'd0, m_rdd} << 15) | ({29'd0, m_err} << 12);
  endfunction

  // per-cycle comparison, 4 ns after the negedge where inputs change
  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      chk("R6 valid", {31'd0, bus_req_valid}, {31'd0, m_state == 1});
      if (m_state == 1) begin
        chk("R1 write", {31'd0, bus_req_write}, {31'd0, m_wr});
        chk("R1 wdata", bus_req_wdata, m_data);
        chk("R2 size", {29'd0, bus_req_size}, {29'd0, m_size});
      end
      chk("R2 addr", bus_req_addr, m_addr);
      case (reg_sel)
        2'd0: chk("R9 ctrl", reg_rdata, m_ctrl());
        2'd1: chk("R2 addr reg", reg_rdata, m_addr);
        2'd2: chk("R4 data reg", reg_rdata, m_data);
        default: chk("R11 unused sel", reg_rdata, 32'd0);
      endcase
    end
  end

  // ---------------- bus slave ----------------
  int          lat = 0, stall = 0, cnt = 0;
  logic        inj = 0, pend = 0, acc = 0;
  logic [31:0] cap_addr = 0;
  int          txn = 0, vcyc = 0;

  always @(negedge clk) begin
    bus_rsp_valid = 0;
    if (acc) begin pend = 1; cnt = lat; acc = 0; end
    if (pend) begin
      if (cnt == 0) begin
        bus_rsp_valid = 1; bus_rsp_error = inj; bus_rsp_rdata = ~cap_addr; pend = 0;
      end else cnt--;
    end
    if (bus_req_valid) begin
      if (stall > 0) begin bus_req_ready = 0; stall--; end
      else begin bus_req_ready = 1; acc = 1; cap_addr = bus_req_addr; end
    end else bus_req_ready = 0;
  end

  always @(posedge clk) begin
    if (bus_req_valid) vcyc++;
    if (bus_req_valid && bus_req_ready) txn++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_sel = sel;
    #4 val = reg_rdata;
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_state != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd_reg(2'd0, v); chk("R11 ctrl", v, 32'h0);
    rd_reg(2'd1, v); chk("R11 addr", v, 32'h0);
    rd_reg(2'd2, v); chk("R11 data", v, 32'h0);
    chk("R11 valid", {31'd0, bus_req_valid}, 32'd0);

    // R1 store, no increment
    wr_reg(2'd0, 32'h0004_0000);
    wr_reg(2'd1, 32'h0000_1000);
    wr_reg(2'd2, 32'hDEAD_BEEF);
    #4;
    chk("R1 valid", {31'd0, bus_req_valid}, 32'd1);
    chk("R1 write", {31'd0, bus_req_write}, 32'd1);
    chk("R1 addr", bus_req_addr, 32'h0000_1000);
    chk("R1 wdata", bus_req_wdata, 32'hDEAD_BEEF);
    wait_idle();
    rd_reg(2'd1, v); chk("R2 no increment", v, 32'h0000_1000);

    // R2 increment per size
    wr_reg(2'd1, 32'h0000_0100);
    for (int s = 0; s < 4; s++) begin
      wr_reg(2'd0, 32'h0001_0000 | (s << 17));
      wr_reg(2'd2, 32'h1111_0000 + s);
      wait_idle();
    end
    rd_reg(2'd1, v); chk("R2 sum 1+2+4+8", v, 32'h0000_010F);
    wr_reg(2'd0, 32'h0001_0000 | (1 << 17));
    wr_reg(2'd1, 32'hFFFF_FFFE);
    wr_reg(2'd2, 32'h0000_0001);
    wait_idle();
    rd_reg(2'd1, v); chk("R2 wrap", v, 32'h0000_0000);

    // R3 illegal size, R9 blocking and clearing
    t0 = txn;
    wr_reg(2'd0, 32'h0009_0000);
    wr_reg(2'd2, 32'h0000_0055);
    repeat (3) @(negedge clk);
    chk("R3 no txn", txn - t0, 0);
    rd_reg(2'd0, v); chk("R3 err code", {29'd0, v[14:12]}, 32'd4);
    rd_reg(2'd1, v); chk("R3 addr kept", v, 32'h0);
    rd_reg(2'd2, v); chk("R3 data loaded", v, 32'h0000_0055);
    wr_reg(2'd0, 32'h0005_0000);
    wr_reg(2'd2, 32'h0000_0066);
    repeat (3) @(negedge clk);
    chk("R9 blocked", txn - t0, 0);
    wr_reg(2'd0, 32'h0005_7000);
    rd_reg(2'd0, v); chk("R9 cleared", {29'd0, v[14:12]}, 32'd0);
    wr_reg(2'd2, 32'h0000_0077);
    wait_idle();
    chk("R9 resumed", txn - t0, 1);
    wr_reg(2'd0, 32'h001E_0000);
    wr_reg(2'd1, 32'h0000_0040);
    repeat (3) @(negedge clk);
    rd_reg(2'd0, v); chk("R3 size7 read", {29'd0, v[14:12]}, 32'd4);
    chk("R3 size7 no txn", txn - t0, 1);
    wr_reg(2'd0, 32'h0000_7000);

    // R4 read on address write
    wr_reg(2'd0, 32'h0015_0000);
    wr_reg(2'd1, 32'h0000_2000);
    wait_idle();
    rd_reg(2'd2, v); chk("R4 data", v, 32'hFFFF_DFFF);
    rd_reg(2'd1, v); chk("R4 addr inc", v, 32'h0000_2004);

    // R5 read on data read
    wr_reg(2'd0, 32'h0004_8000);
    t0 = txn;
    rd_reg(2'd2, v); chk("R5 old value", v, 32'hFFFF_DFFF);
    wait_idle();
    wr_reg(2'd0, 32'h0004_0000);
    rd_reg(2'd2, v); chk("R5 new value", v, 32'hFFFF_DFFB);
    chk("R5 one read", txn - t0, 1);

    // R6 R7 R10 with a stalling, slow slave
    lat = 4; stall = 3;
    wr_reg(2'd1, 32'h0000_3000);
    t0 = vcyc;
    wr_reg(2'd2, 32'h0000_1234);
    rd_reg(2'd0, v); chk("R6 busy seen", {31'd0, v[21]}, 32'd1);
    wr_reg(2'd1, 32'h0000_9999);
    wait_idle();
    chk("R10 valid held", vcyc - t0, 4);
    rd_reg(2'd1, v); chk("R7 addr ignored", v, 32'h0000_3000);
    rd_reg(2'd0, v); chk("R7 flag set", {31'd0, v[22]}, 32'd1);
    chk("R6 busy clear", {31'd0, v[21]}, 32'd0);
    wr_reg(2'd0, 32'h0044_0000);
    rd_reg(2'd0, v); chk("R7 flag cleared", v, 32'h0004_0000);
    lat = 0; stall = 0;

    // R8 bus error on write and on read
    inj = 1;
    wr_reg(2'd0, 32'h0005_0000);
    wr_reg(2'd1, 32'h0000_4000);
    wr_reg(2'd2, 32'h0000_00AA);
    wait_idle();
    rd_reg(2'd0, v); chk("R8 err code", {29'd0, v[14:12]}, 32'd2);
    rd_reg(2'd1, v); chk("R8 addr kept", v, 32'h0000_4000);
    wr_reg(2'd0, 32'h0015_7000);
    wr_reg(2'd1, 32'h0000_5000);
    wait_idle();
    rd_reg(2'd2, v); chk("R8 data kept", v, 32'h0000_00AA);
    rd_reg(2'd1, v); chk("R8 read addr kept", v, 32'h0000_5000);
    inj = 0;

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule